// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Controller

This block raises the interrupt line of a real-time clock. It takes two kinds of event. The first is an alarm: the running time, made up of hundredths, seconds, minutes, hours, date, month and weekday, matches a time stored in seven alarm fields. Any of those fields can be excluded from the comparison. The second kind is periodic: six rollover strobes from the time counter chain. Each of the seven sources passes through a mask. An enabled event latches a flag in a status byte. The interrupt output is a level that stays high until the host reads the status.

The host reaches the block through a simple write port and a status-read strobe. When the backup input is high, the block drops all host accesses but keeps recording events. The counters, the bus timing and the read data path outside the status byte belong to the surrounding clock.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, every status flag is 0, the interrupt output is low, and the mask and all compare enables are cleared. With the mask cleared, no source can set a flag.
- R2: When `tick` is high and every enabled alarm field equals its byte of `now_time`, status bit 6 and bit 7 become set after that clock edge. Byte k of `now_time` is bits [8k+7:8k], in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 date, 5 month, 6 weekday.
- R3: A field whose compare-enable bit is 0 is ignored in the comparison. If all compare-enable bits are 0, the alarm never fires.
- R4: The alarm fires only on the first tick on which the enabled fields match. Later ticks that keep matching do not set it again until a tick with no match has passed.
- R5: A high bit i of `roll_in` sets status bit i and bit 7 when mask bit i is 1. The bit order is 0 = 1/100 s, 1 = 1/10 s, 2 = second, 3 = minute, 4 = hour, 5 = day.
- R6: A source whose mask bit is 0 sets no flag. Mask bit 6 gates the alarm.
- R7: Status bit 7 is set whenever any other flag is set. `irq_o` equals bit 7, and flags stay set until a clearing read.
- R8: A status read (`stat_rd` high outside backup) clears all flags on the following edge. An enabled event arriving in the same cycle as the read is kept set.
- R9: While `bkup` is high, host writes and status reads are ignored, and events still set flags.
- R10: Write addresses: 0 to 6 hold the alarm fields in the byte order of R2, 7 holds the compare enables (data bits 6:0, bit k for field k), and 8 holds the mask (data bits 6:0). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bkup | input | 1 | Backup mode; blocks host access |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Write address |
| host_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; clears flags |
| stat_q | output | 8 | Status flags; bit 7 is the summary flag |
| irq_o | output | 1 | Level interrupt, active high |
| tick | input | 1 | Time counters hold a new value this cycle |
| now_time | input | 56 | Current time, seven bytes |
| roll_in | input | 6 | Periodic rollover strobes |

## Verification
A corrupted alarm field or compare enable shows up as a missing or extra bit 6 on the very next matching tick. A lost first-match register shows up as a repeated alarm on the tick after a clearing read. A mask or flag fault appears in `stat_q` one edge after the event or read that exposes it, and `irq_o` follows in the same cycle. Long random runs with small time values make matches frequent, so each of these faults is exposed within a few dozen cycles.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int FW = 8,
  parameter int NF = 7,
  parameter int NP = 6,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkup,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [7:0]       host_wdata,
  input  logic             stat_rd,
  output logic [NP+1:0]    stat_q,
  output logic             irq_o,
  input  logic             tick,
  input  logic [NF*FW-1:0] now_time,
  input  logic [NP-1:0]    roll_in
);
  localparam int EN_ADDR = NF;
  localparam int MK_ADDR = NF + 1;

  logic [NF*FW-1:0] alarm_v;
  logic [NF-1:0]    cmp_en;
  logic [NP:0]      mask;
  logic [NP+1:0]    flags;
  logic [NF-1:0]    fld_ok;
  logic             hit, hit_q, alarm_ev, host_ok, clr;
  logic [NP:0]      ev;

  assign host_ok = !bkup;
  assign clr     = stat_rd && host_ok;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n) alarm_v[i*FW +: FW] <= '0;
      else if (host_wr && host_ok && host_addr == AW'(i))
        alarm_v[i*FW +: FW] <= host_wdata[FW-1:0];
    end
    assign fld_ok[i] = !cmp_en[i] || (now_time[i*FW +: FW] == alarm_v[i*FW +: FW]);
  end

  assign hit      = (|cmp_en) && (&fld_ok);
  assign alarm_ev = tick && hit && !hit_q;
  assign ev       = {alarm_ev, roll_in} & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_en <= '0;
      mask   <= '0;
      hit_q  <= 1'b0;
      flags  <= '0;
    end else begin
      if (host_wr && host_ok && host_addr == AW'(EN_ADDR)) cmp_en <= host_wdata[NF-1:0];
      if (host_wr && host_ok && host_addr == AW'(MK_ADDR)) mask   <= host_wdata[NP:0];
      if (tick) hit_q <= hit;
      flags <= (clr ? '0 : flags) | {|ev, ev};
    end
  end

  assign stat_q = flags;
  assign irq_o  = flags[NP+1];
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int NP = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bkup,
  input logic          stat_rd,
  input logic          tick,
  input logic [NP-1:0] roll_in,
  input logic [NP+1:0] stat_q,
  input logic [NP:0]   mask
);
  assert_alarm_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[NP]) |-> $past(tick));

  assert_periodic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(roll_in & mask[NP-1:0])) |=>
      ((stat_q[NP-1:0] & $past(roll_in & mask[NP-1:0])) == $past(roll_in & mask[NP-1:0])));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (roll_in & mask[NP-1:0]) == '0 && !stat_rd) |=> $stable(stat_q));

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd || bkup) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !bkup && !tick && roll_in == '0) |=> (stat_q == '0));

  assert_backup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup && !tick && roll_in == '0) |=> $stable(stat_q));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bkup(bkup), .stat_rd(stat_rd), .tick(tick),
  .roll_in(roll_in), .stat_q(stat_q), .mask(mask)
);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkup = 1'b0, host_wr = 1'b0, stat_rd = 1'b0, tick = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [55:0] now_time = '0;
  logic [5:0]  roll_in = '0;
  logic [7:0]  stat_q;
  logic        irq_o;

  int checks = 0, fails = 0;

  logic [7:0] m_al [7];
  logic [6:0] m_en, m_mask;
  logic       m_prev;
  logic [7:0] m_fl;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bkup(bkup), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .stat_rd(stat_rd), .stat_q(stat_q), .irq_o(irq_o),
    .tick(tick), .now_time(now_time), .roll_in(roll_in)
  );

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(logic [55:0] tm);
    logic h = |m_en;
    for (int i = 0; i < 7; i++)
      if (m_en[i] && tm[i*8 +: 8] != m_al[i]) h = 1'b0;
    return h;
  endfunction

  task automatic step(string tag, logic t, logic [55:0] tm, logic [5:0] r,
                      logic rd, logic bk, logic wr, logic [3:0] a, logic [7:0] d);
    logic hit, aev;
    logic [6:0] ev;
    @(negedge clk);
    tick = t; now_time = tm; roll_in = r; stat_rd = rd; bkup = bk;
    host_wr = wr; host_addr = a; host_wdata = d;
    hit = model_hit(tm);
    aev = t && hit && !m_prev;
    ev  = {aev, r} & m_mask;
    m_fl = ((rd && !bk) ? 8'h00 : m_fl) | {|ev, ev};
    if (wr && !bk) begin
      if (a < 4'd7) m_al[a] = d;
      else if (a == 4'd7) m_en = d[6:0];
      else if (a == 4'd8) m_mask = d[6:0];
    end
    if (t) m_prev = hit;
    @(posedge clk); #1;
    chk(tag, {irq_o, stat_q}, {m_fl[7], m_fl});
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step("R10", 1'b0, now_time, 6'h0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd_clear(string tag);
    step(tag, 1'b0, now_time, 6'h0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m_al[i] = '0;
    m_en = '0; m_mask = '0; m_prev = 1'b0; m_fl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", {irq_o, stat_q}, 9'h000);
    step("R1", 1'b1, '0, 6'h3F, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R1", {1'b0, stat_q}, 9'h000);

    wr(4'd8, 8'h7F);
    wr(4'd7, 8'h04);
    wr(4'd2, 8'h05);
    wr(4'd12, 8'hFF);
    step("R2", 1'b1, 56'h00_00_00_00_05_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R2", {irq_o, stat_q}, {1'b1, 8'hC0});
    rd_clear("R8");
    chk("R8", {irq_o, stat_q}, 9'h000);
    step("R4", 1'b1, 56'h00_00_00_00_05_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R4", {1'b0, stat_q}, 9'h000);
    step("R4", 1'b1, 56'h00_00_00_00_06_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    step("R4", 1'b1, 56'h00_00_00_00_05_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R4", {1'b0, stat_q}, 9'h0C0);
    rd_clear("R8");

    step("R3", 1'b1, 56'h09_09_09_09_05_09_09, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    wr(4'd7, 8'h00);
    step("R3", 1'b1, 56'h00_00_00_00_05_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R3", {1'b0, stat_q}, 9'h000);
    wr(4'd12, 8'h7F);
    step("R10", 1'b1, 56'h00_00_00_00_05_00_00, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R10", {1'b0, stat_q}, 9'h000);

    for (int i = 0; i < 6; i++) begin
      step("R5", 1'b0, '0, 6'(1 << i), 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
      chk("R5", {1'b0, stat_q}, {1'b0, 8'h80 | 8'(1 << i)});
      rd_clear("R8");
    end
    wr(4'd8, 8'h40);
    step("R6", 1'b0, '0, 6'h3F, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R6", {irq_o, stat_q}, 9'h000);
    wr(4'd8, 8'h7F);

    step("R7", 1'b0, '0, 6'h04, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    repeat (5) step("R7", 1'b0, '0, 6'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R7", {irq_o, stat_q}, {1'b1, 8'h84});
    step("R8", 1'b0, '0, 6'h01, 1'b1, 1'b0, 1'b0, 4'h0, 8'h0);
    chk("R8", {irq_o, stat_q}, {1'b1, 8'h81});
    rd_clear("R8");

    step("R9", 1'b0, '0, 6'h10, 1'b0, 1'b1, 1'b0, 4'h0, 8'h0);
    step("R9", 1'b0, '0, 6'h0, 1'b1, 1'b1, 1'b1, 4'd8, 8'h00);
    chk("R9", {irq_o, stat_q}, {1'b1, 8'h90});
    step("R9", 1'b0, '0, 6'h02, 1'b0, 1'b1, 1'b0, 4'h0, 8'h0);
    chk("R9", {irq_o, stat_q}, {1'b1, 8'h92});
    rd_clear("R8");

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [55:0] tm;
      logic [3:0]  a;
      for (int k = 0; k < 7; k++) tm[k*8 +: 8] = 8'($urandom_range(0, 1));
      a = 4'($urandom_range(0, 10));
      step("R7", 1'($urandom_range(0, 1)), tm,
           6'($urandom) & 6'($urandom) & 6'($urandom),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 5) == 0), a,
           (a == 4'd7 || a == 4'd8) ? 8'($urandom) : 8'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule